// File: doc/BRIEF.md
# Accumulator ALU with Registered Flag Nibble

This block is the arithmetic and logic stage of an accumulator-based 8-bit processor. On each operation it takes the accumulator value and an operand. A group bit and a 3-bit code pick the operation. The block returns the new accumulator value and a write enable for it, and it computes a new flag byte. The flags themselves are held in a register inside the block. That register is loaded only on a one-cycle `alu_valid` strobe. The operations read their carry, half-carry and subtract inputs from this register.

Group 0 holds the eight two-operand operations. Group 1 holds the single-operand accumulator operations: the four rotates, decimal adjust, complement, set carry and complement carry. Decimal adjust reads the stored subtract flag, so it fixes up a packed BCD sum and a packed BCD difference in different ways. The result and `flags_next` are combinational. `flags_q` is the registered flag byte.

Top module: `accum_alu`

## Requirements
- R1: Flag byte layout: bit 7 is Z (zero), bit 6 is N (subtract), bit 5 is H (half-carry) and bit 4 is C (carry). Bits 3..0 of `flags_q` and `flags_next` are always 0. A synchronous `rst` loads `flags_q` with 0xB0.
- R2: `flags_q` takes the value of `flags_next` on a rising clock edge where `alu_valid` is 1, and holds its value otherwise. `result_we` is 0 whenever `alu_valid` is 0.
- R3: Group 0 codes are 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 AND, 5 XOR, 6 OR, 7 CP. ADD and ADC (ADC adds C as a carry-in) produce the 8-bit sum. They set H on a carry out of bit 3, set C on a carry out of bit 7, clear N, and set Z when the sum is 0.
- R4: SUB and SBC (SBC also subtracts C) produce A minus the operand. H is set when the low nibble of A is smaller than the operand's low nibble plus the borrow-in. C is set when the full 8-bit value is smaller. N is set, and Z reflects the difference.
- R5: AND sets H and clears N and C. XOR and OR clear N, H and C. All three set Z when the result is 0.
- R6: CP sets Z, N, H and C exactly as SUB would. It leaves `result_out` equal to `acc_in` and keeps `result_we` at 0.
- R7: Group 1 codes are 0 RLCA, 1 RRCA, 2 RLA, 3 RRA, 4 DAA, 5 CPL, 6 SCF, 7 CCF. Every rotate clears Z, N and H. RLCA and RRCA move the bit that leaves the byte both into C and into the vacated bit. RLA and RRA put the old C into the vacated bit and the leaving bit into C.
- R8: DAA with N=0: if C is 1 or A > 0x99, it adds 0x60 and sets C. Then, if H is 1 or the low nibble of that value is > 9, it adds 0x06. Otherwise C is unchanged.
- R9: DAA with N=1: it subtracts 0x60 only when C is 1, then subtracts 0x06 only when H is 1, and leaves C as it was. For both directions of DAA, H is cleared, N is kept and Z reflects the result.
- R10: CPL writes the bitwise complement of A, sets N and H, and keeps Z and C.
- R11: SCF sets C and CCF inverts C. Both clear N and H and keep Z. Neither writes the accumulator: `result_out` equals `acc_in` and `result_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| alu_valid | input | 1 | One-cycle strobe that commits the operation |
| alu_misc | input | 1 | Operation group: 0 two-operand, 1 accumulator-only |
| alu_op | input | 3 | Operation code within the group |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Second operand (group 0 only) |
| result_out | output | 8 | New accumulator value |
| result_we | output | 1 | Accumulator write enable |
| flags_next | output | 8 | Flag byte the operation produces |
| flags_q | output | 8 | Registered flag byte |

## Verification
A few thousand random mixes of group, code, accumulator and operand are applied. Each one runs against the flag state left by the previous operation, so ADC, SBC, the through-carry rotates and DAA meet both values of every incoming flag. Directed operand pairs then separate the edge conditions that random values rarely reach. These include a nibble carry with no byte carry and a byte carry with no nibble carry. They also include a borrow-in that alone causes the borrow, compare of equal values, and DAA right at 0x99 and 0x9A. DAA is also applied after a subtraction, once with and once without a half-borrow. Idle cycles that present flag-changing operations with the strobe low show whether the register holds its value.

// File: rtl/accum_alu_pkg.sv
package accum_alu_pkg;

  localparam int FLAG_Z_BIT = 7;
  localparam int FLAG_N_BIT = 6;
  localparam int FLAG_H_BIT = 5;
  localparam int FLAG_C_BIT = 4;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBC = 3'd3,
    OP_AND = 3'd4,
    OP_XOR = 3'd5,
    OP_OR  = 3'd6,
    OP_CP  = 3'd7
  } arith_op_e;

  typedef enum logic [2:0] {
    AX_RLC  = 3'd0,
    AX_RRC  = 3'd1,
    AX_RL   = 3'd2,
    AX_RR   = 3'd3,
    AX_DADJ = 3'd4,
    AX_CPL  = 3'd5,
    AX_SCF  = 3'd6,
    AX_CCF  = 3'd7
  } aux_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flag_t;

endpackage

// File: rtl/accum_alu_core.sv
module accum_alu_core
  import accum_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  arith_op_e     op,
  input  flag_t         fin,
  output logic [DW-1:0] res,
  output flag_t         fout,
  output logic          we
);
  localparam int NW = DW / 2;

  logic          cin;
  logic          sub_path;
  logic [NW:0]   lo;
  logic [DW:0]   wide;
  logic [DW-1:0] logic_v;

  always_comb begin
    cin      = ((op == OP_ADC) || (op == OP_SBC)) ? fin.c : 1'b0;
    sub_path = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CP);
    if (sub_path) begin
      lo   = {1'b0, a[NW-1:0]} - {1'b0, b[NW-1:0]} - {{NW{1'b0}}, cin};
      wide = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin};
    end else begin
      lo   = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
      wide = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
    end
  end

  always_comb begin
    logic_v = a;
    case (op)
      OP_AND:  logic_v = a & b;
      OP_XOR:  logic_v = a ^ b;
      OP_OR:   logic_v = a | b;
      default: logic_v = a;
    endcase
  end

  always_comb begin
    res  = a;
    fout = fin;
    we   = 1'b1;
    case (op)
      OP_ADD, OP_ADC: begin
        res    = wide[DW-1:0];
        fout.z = (wide[DW-1:0] == '0);
        fout.n = 1'b0;
        fout.h = lo[NW];
        fout.c = wide[DW];
      end
      OP_SUB, OP_SBC, OP_CP: begin
        res    = (op == OP_CP) ? a : wide[DW-1:0];
        we     = (op != OP_CP);
        fout.z = (wide[DW-1:0] == '0);
        fout.n = 1'b1;
        fout.h = lo[NW];
        fout.c = wide[DW];
      end
      default: begin
        res    = logic_v;
        fout.z = (logic_v == '0);
        fout.n = 1'b0;
        fout.h = (op == OP_AND);
        fout.c = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/accum_alu_aux.sv
module accum_alu_aux
  import accum_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  aux_op_e       op,
  input  flag_t         fin,
  output logic [DW-1:0] res,
  output flag_t         fout,
  output logic          we
);
  localparam int            NW      = DW / 2;
  localparam logic [DW-1:0] ADJ_HI  = DW'(8'h60);
  localparam logic [DW-1:0] ADJ_LO  = DW'(8'h06);
  localparam logic [DW-1:0] DEC_MAX = DW'(8'h99);
  localparam logic [NW-1:0] NIB_MAX = NW'(9);

  logic [DW-1:0] step;
  logic          hi_fix;

  always_comb begin
    res    = a;
    fout   = fin;
    we     = 1'b1;
    step   = a;
    hi_fix = 1'b0;
    case (op)
      AX_RLC: begin
        res  = {a[DW-2:0], a[DW-1]};
        fout = '{z: 1'b0, n: 1'b0, h: 1'b0, c: a[DW-1]};
      end
      AX_RRC: begin
        res  = {a[0], a[DW-1:1]};
        fout = '{z: 1'b0, n: 1'b0, h: 1'b0, c: a[0]};
      end
      AX_RL: begin
        res  = {a[DW-2:0], fin.c};
        fout = '{z: 1'b0, n: 1'b0, h: 1'b0, c: a[DW-1]};
      end
      AX_RR: begin
        res  = {fin.c, a[DW-1:1]};
        fout = '{z: 1'b0, n: 1'b0, h: 1'b0, c: a[0]};
      end
      AX_DADJ: begin
        if (!fin.n) begin
          hi_fix = fin.c || (a > DEC_MAX);
          step   = hi_fix ? a + ADJ_HI : a;
          res    = (fin.h || (step[NW-1:0] > NIB_MAX)) ? step + ADJ_LO : step;
          fout.c = hi_fix;
        end else begin
          step   = fin.c ? a - ADJ_HI : a;
          res    = fin.h ? step - ADJ_LO : step;
          fout.c = fin.c;
        end
        fout.z = (res == '0);
        fout.h = 1'b0;
      end
      AX_CPL: begin
        res    = ~a;
        fout.n = 1'b1;
        fout.h = 1'b1;
      end
      AX_SCF: begin
        we     = 1'b0;
        fout.n = 1'b0;
        fout.h = 1'b0;
        fout.c = 1'b1;
      end
      default: begin
        we     = 1'b0;
        fout.n = 1'b0;
        fout.h = 1'b0;
        fout.c = ~fin.c;
      end
    endcase
  end

endmodule

// File: rtl/accum_alu_flags.sv
module accum_alu_flags
  import accum_alu_pkg::*;
#(
  parameter logic [3:0] RST_NIB = 4'hB
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  flag_t d,
  output flag_t q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= flag_t'(RST_NIB);
    else if (en) q <= d;
  end

endmodule

// File: rtl/accum_alu.sv
module accum_alu
  import accum_alu_pkg::*;
#(
  parameter int         DATA_W    = 8,
  parameter logic [7:0] FLAG_INIT = 8'hB0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alu_valid,
  input  logic              alu_misc,
  input  logic [2:0]        alu_op,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] opnd_in,
  output logic [DATA_W-1:0] result_out,
  output logic              result_we,
  output logic [7:0]        flags_next,
  output logic [7:0]        flags_q
);

  flag_t              cur_f;
  flag_t              core_f;
  flag_t              aux_f;
  flag_t              sel_f;
  logic [DATA_W-1:0]  core_res;
  logic [DATA_W-1:0]  aux_res;
  logic               core_we;
  logic               aux_we;

  accum_alu_core #(.DW(DATA_W)) u_core (
    .a    (acc_in),
    .b    (opnd_in),
    .op   (arith_op_e'(alu_op)),
    .fin  (cur_f),
    .res  (core_res),
    .fout (core_f),
    .we   (core_we)
  );

  accum_alu_aux #(.DW(DATA_W)) u_aux (
    .a    (acc_in),
    .op   (aux_op_e'(alu_op)),
    .fin  (cur_f),
    .res  (aux_res),
    .fout (aux_f),
    .we   (aux_we)
  );

  always_comb begin
    if (alu_misc) begin
      result_out = aux_res;
      sel_f      = aux_f;
      result_we  = alu_valid & aux_we;
    end else begin
      result_out = core_res;
      sel_f      = core_f;
      result_we  = alu_valid & core_we;
    end
  end

  assign flags_next = {sel_f, 4'b0000};

  accum_alu_flags #(.RST_NIB(FLAG_INIT[7:4])) u_flags (
    .clk (clk),
    .rst (rst),
    .en  (alu_valid),
    .d   (sel_f),
    .q   (cur_f)
  );

  assign flags_q = {cur_f, 4'b0000};

  // R1: the cycle after reset the flag byte holds its reset value
  a_r1_reset_value: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (flags_q == FLAG_INIT));

  // R2: no strobe, no change
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !alu_valid |=> $stable(flags_q));

  // R2: a strobe commits the computed flags
  a_r2_commit: assert property (@(posedge clk) disable iff (rst)
    alu_valid |=> (flags_q == $past(flags_next)));

  // R6: compare leaves the accumulator alone
  a_r6_cp_no_write: assert property (@(posedge clk) disable iff (rst)
    (alu_valid && !alu_misc && alu_op == 3'd7) |-> (!result_we && result_out == acc_in));

  // R7: a committed rotate leaves Z, N and H clear
  a_r7_rot_clears: assert property (@(posedge clk) disable iff (rst)
    (alu_valid && alu_misc && !alu_op[2]) |=> (flags_q[7:5] == 3'b000));

  // R9: decimal adjust clears H and keeps N
  a_r9_dadj_h_n: assert property (@(posedge clk) disable iff (rst)
    (alu_valid && alu_misc && alu_op == 3'd4) |=>
      (!flags_q[5] && flags_q[6] == $past(flags_q[6])));

endmodule

// File: tb/accum_alu_test.sv
module accum_alu_test;

  logic       clk = 1'b0;
  logic       rst;
  logic       alu_valid;
  logic       alu_misc;
  logic [2:0] alu_op;
  logic [7:0] acc_in;
  logic [7:0] opnd_in;
  logic [7:0] result_out;
  logic       result_we;
  logic [7:0] flags_next;
  logic [7:0] flags_q;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;
  logic [7:0] mf;

  always #10 clk = ~clk;

  accum_alu uut (
    .clk        (clk),
    .rst        (rst),
    .alu_valid  (alu_valid),
    .alu_misc   (alu_misc),
    .alu_op     (alu_op),
    .acc_in     (acc_in),
    .opnd_in    (opnd_in),
    .result_out (result_out),
    .result_we  (result_we),
    .flags_next (flags_next),
    .flags_q    (flags_q)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // returns {we, result, flag byte}
  function automatic logic [16:0] model(bit misc, logic [2:0] op,
                                        logic [7:0] a, logic [7:0] b, logic [7:0] f);
    int ai = a; int bi = b; int ci; int r;
    bit z = f[7]; bit n = f[6]; bit h = f[5]; bit c = f[4];
    bit we = 1;
    logic [7:0] res = a;
    if (!misc) begin
      case (op)
        3'd0, 3'd1: begin
          ci = (op == 3'd1) ? int'(c) : 0;
          r = ai + bi + ci;
          h = ((ai % 16) + (bi % 16) + ci) > 15;
          c = r > 255; res = r[7:0]; n = 0; z = (res == 0);
        end
        3'd2, 3'd3, 3'd7: begin
          ci = (op == 3'd3) ? int'(c) : 0;
          h = (ai % 16) < ((bi % 16) + ci);
          c = ai < (bi + ci);
          r = ai - bi - ci; res = r[7:0]; n = 1; z = (res == 0);
          if (op == 3'd7) begin res = a; we = 0; end
        end
        3'd4: begin res = a & b; z = (res == 0); n = 0; h = 1; c = 0; end
        3'd5: begin res = a ^ b; z = (res == 0); n = 0; h = 0; c = 0; end
        default: begin res = a | b; z = (res == 0); n = 0; h = 0; c = 0; end
      endcase
    end else begin
      case (op)
        3'd0: begin res = {a[6:0], a[7]}; c = a[7]; z = 0; n = 0; h = 0; end
        3'd1: begin res = {a[0], a[7:1]}; c = a[0]; z = 0; n = 0; h = 0; end
        3'd2: begin res = {a[6:0], c}; c = a[7]; z = 0; n = 0; h = 0; end
        3'd3: begin res = {c, a[7:1]}; c = a[0]; z = 0; n = 0; h = 0; end
        3'd4: begin
          r = ai;
          if (!n) begin
            if (c || ai > 153) begin r = r + 96; c = 1; end
            if (h || (r % 16) > 9) r = r + 6;
          end else begin
            if (c) r = r - 96;
            if (h) r = r - 6;
          end
          res = r[7:0]; z = (res == 0); h = 0;
        end
        3'd5: begin res = ~a; n = 1; h = 1; end
        3'd6: begin we = 0; n = 0; h = 0; c = 1; end
        default: begin we = 0; n = 0; h = 0; c = ~c; end
      endcase
    end
    return {we, res, z, n, h, c, 4'b0000};
  endfunction

  function automatic string tag_of(bit misc, logic [2:0] op);
    if (!misc) begin
      case (op)
        3'd0, 3'd1: return "R3";
        3'd2, 3'd3: return "R4";
        3'd7:       return "R6";
        default:    return "R5";
      endcase
    end
    case (op)
      3'd4:    return (mf[6] ? "R9" : "R8");
      3'd5:    return "R10";
      3'd6, 3'd7: return "R11";
      default: return "R7";
    endcase
  endfunction

  task automatic do_op(input bit misc, input logic [2:0] op,
                       input logic [7:0] a, input logic [7:0] b);
    logic [16:0] e;
    string t;
    @(negedge clk);
    t = tag_of(misc, op);
    alu_valid = 1; alu_misc = misc; alu_op = op; acc_in = a; opnd_in = b;
    #2;
    e = model(misc, op, a, b, mf);
    chk({t, " result"}, {24'd0, result_out}, {24'd0, e[15:8]});
    chk({t, " write enable"}, {31'd0, result_we}, {31'd0, e[16]});
    chk({t, " next flags"}, {24'd0, flags_next}, {24'd0, e[7:0]});
    @(posedge clk);
    #2;
    alu_valid = 0;
    mf = e[7:0];
    chk({t, " R2 committed flags"}, {24'd0, flags_q}, {24'd0, mf});
  endtask

  task automatic idle_op(input bit misc, input logic [2:0] op, input logic [7:0] a);
    @(negedge clk);
    alu_valid = 0; alu_misc = misc; alu_op = op; acc_in = a; opnd_in = 8'h55;
    #2;
    chk("R2 write enable idle", {31'd0, result_we}, 32'd0);
    @(posedge clk);
    #2;
    chk("R2 flags held idle", {24'd0, flags_q}, {24'd0, mf});
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    rst = 1; alu_valid = 0; alu_misc = 0; alu_op = 0; acc_in = 0; opnd_in = 0;
    seed = $urandom(32'd20231);
    repeat (3) @(negedge clk);
    rst = 0;
    #2;
    mf = 8'hB0;
    chk("R1 reset flags", {24'd0, flags_q}, 32'h0000_00B0);
    chk("R2 no write enable without strobe", {31'd0, result_we}, 32'd0);

    idle_op(1'b1, 3'd7, 8'h12);
    idle_op(1'b0, 3'd2, 8'h00);

    // R3 nibble and byte carries
    do_op(1'b0, 3'd0, 8'h3A, 8'hC6);
    do_op(1'b0, 3'd1, 8'h0F, 8'h00);
    do_op(1'b0, 3'd0, 8'hF0, 8'h20);
    do_op(1'b0, 3'd1, 8'h7F, 8'h80);
    // R4 borrows
    do_op(1'b0, 3'd2, 8'h10, 8'h01);
    do_op(1'b1, 3'd6, 8'h00, 8'h00);
    do_op(1'b0, 3'd3, 8'h00, 8'h00);
    do_op(1'b0, 3'd3, 8'h50, 8'h4F);
    // R5 logic
    do_op(1'b0, 3'd4, 8'hF0, 8'h0F);
    do_op(1'b0, 3'd5, 8'hAA, 8'hAA);
    do_op(1'b0, 3'd6, 8'h00, 8'h01);
    // R6 compare
    do_op(1'b0, 3'd7, 8'h42, 8'h42);
    do_op(1'b0, 3'd7, 8'h10, 8'h20);
    // R8 adjust after additions
    do_op(1'b0, 3'd0, 8'h45, 8'h38);
    do_op(1'b1, 3'd4, 8'h7D, 8'h00);
    do_op(1'b0, 3'd0, 8'h99, 8'h01);
    do_op(1'b1, 3'd4, 8'h9A, 8'h00);
    do_op(1'b0, 3'd0, 8'h90, 8'h09);
    do_op(1'b1, 3'd4, 8'h99, 8'h00);
    // R9 adjust after subtractions
    do_op(1'b0, 3'd2, 8'h42, 8'h15);
    do_op(1'b1, 3'd4, 8'h2D, 8'h00);
    do_op(1'b0, 3'd2, 8'h20, 8'h30);
    do_op(1'b1, 3'd4, 8'hF0, 8'h00);
    // R7 rotates
    do_op(1'b1, 3'd0, 8'h81, 8'h00);
    do_op(1'b1, 3'd1, 8'h81, 8'h00);
    do_op(1'b1, 3'd2, 8'h80, 8'h00);
    do_op(1'b1, 3'd3, 8'h01, 8'h00);
    // R10 and R11
    do_op(1'b1, 3'd5, 8'h35, 8'h00);
    do_op(1'b1, 3'd6, 8'h35, 8'h00);
    do_op(1'b1, 3'd7, 8'h35, 8'h00);
    do_op(1'b1, 3'd7, 8'h35, 8'h00);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] rv;
      rv = $urandom();
      do_op(rv[24], rv[18:16], rv[7:0], rv[15:8]);
      if (rv[31:29] == 3'd0) idle_op(rv[23], rv[22:20], rv[7:0]);
    end

    chk("R1 low nibble zero", {28'd0, flags_q[3:0]}, 32'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule